// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Signed and Unsigned Modes

This block multiplies two 16-bit operands in a single clock cycle and folds the product into a 48-bit accumulator. An operation code picks one of seven variants. Three variants treat the operands as unsigned: load the product, add it, or subtract it. Four variants treat them as two's-complement: load the product, load its negation, add it, or subtract it. Signed products are sign-extended to the accumulator width, and unsigned products are zero-extended.

A caller presents the operands and the code and raises the start strobe for one cycle. On the next clock edge the accumulator takes its new value, and a done pulse marks that cycle. A separate clear input zeroes the accumulator. Clear wins over a start in the same cycle. All arithmetic wraps modulo 2^48 and never saturates.

Top module: `mac_unit`

## Requirements
- R1: While reset (active low, synchronous) is applied and on the first cycle after it, `acc` is 0 and `done` is 0.
- R2: Code 0 (unsigned multiply) with start loads `acc` with the zero-extended unsigned product of `opa` and `opb`, one clock after the strobe.
- R3: Code 1 (unsigned multiply-accumulate) adds the zero-extended unsigned product to `acc`.
- R4: Code 2 (unsigned multiply-subtract) subtracts the zero-extended unsigned product from `acc`.
- R5: Code 3 (signed multiply) loads `acc` with the two's-complement product, sign-extended to 48 bits.
- R6: Code 4 (signed multiply-negate) loads `acc` with the negated two's-complement product, sign-extended to 48 bits.
- R7: Code 5 (signed multiply-accumulate) adds the sign-extended signed product to `acc`.
- R8: Code 6 (signed multiply-subtract) subtracts the sign-extended signed product from `acc`.
- R9: A start with code 7 changes nothing: `acc` holds its value and `done` stays 0.
- R10: Accumulator arithmetic wraps modulo 2^48. For example, an unsigned subtract of 1 from 0 gives 0xFFFF_FFFF_FFFF.
- R11: `acc_clr` sets `acc` to 0 on the next edge and overrides a start in the same cycle. That start produces no `done` and no update.
- R12: `done` is 1 for exactly the cycle after a start with a valid code (0 to 6) and no clear, and 0 otherwise. Without a start, `acc` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| op_sel | input | 3 | Operation code, 0 to 6 valid, 7 ignored |
| start | input | 1 | One-cycle strobe that requests an operation |
| acc_clr | input | 1 | Accumulator clear, has priority over start |
| acc | output | 48 | Accumulator value |
| done | output | 1 | One-cycle pulse when an update becomes visible |

## Verification
The accumulator is the only state in the block, so any wrong internal value shows on `acc` one edge after the operation that caused it. Because accumulation carries history, the error also persists in every later value until a clear or a load. Several problems can appear as a wrong upper 16 bits in the cycle after a negative signed product: a swapped signed/unsigned decode, a lost sign extension, or a wrong subtract direction. A faulty priority between clear and start shows up at once, either as a stray `done` pulse or as a nonzero `acc` after a clear. The bench predicts both outputs every cycle from a behavioural model, so any of these differences is caught on the cycle it first appears.

// File: rtl/mac_pkg.sv
// Package: shared types for the multiply-accumulate unit.
// Assumes a 3-bit operation code whose numeric values are fixed by the ports.
package mac_pkg;

    typedef enum logic [2:0] {
        OP_UMUL = 3'd0,
        OP_UMAC = 3'd1,
        OP_UMSU = 3'd2,
        OP_SMUL = 3'd3,
        OP_SNEG = 3'd4,
        OP_SMAC = 3'd5,
        OP_SMSU = 3'd6,
        OP_NONE = 3'd7
    } mac_op_e;

    // How the extended product is combined with the accumulator.
    typedef enum logic [1:0] {
        UPD_LOAD    = 2'd0,
        UPD_LOADNEG = 2'd1,
        UPD_ADD     = 2'd2,
        UPD_SUB     = 2'd3
    } upd_e;

    typedef struct packed {
        logic valid;
        logic is_signed;
        upd_e upd;
    } mac_ctl_t;

endpackage

// File: rtl/mac_op_decode.sv
// Module: mac_op_decode
// Turns the operation code into a control word: whether the code is valid,
// whether operands are two's-complement, and how the accumulator is updated.
// Assumes: purely combinational, code 7 is the only invalid code.
module mac_op_decode
    import mac_pkg::*;
(
    input  logic [2:0] op_sel,
    output mac_ctl_t   ctl
);

    // Map each code to its control word.
    always_comb begin
        ctl = '{valid: 1'b0, is_signed: 1'b0, upd: UPD_LOAD};
        case (op_sel)
            OP_UMUL: ctl = '{valid: 1'b1, is_signed: 1'b0, upd: UPD_LOAD};
            OP_UMAC: ctl = '{valid: 1'b1, is_signed: 1'b0, upd: UPD_ADD};
            OP_UMSU: ctl = '{valid: 1'b1, is_signed: 1'b0, upd: UPD_SUB};
            OP_SMUL: ctl = '{valid: 1'b1, is_signed: 1'b1, upd: UPD_LOAD};
            OP_SNEG: ctl = '{valid: 1'b1, is_signed: 1'b1, upd: UPD_LOADNEG};
            OP_SMAC: ctl = '{valid: 1'b1, is_signed: 1'b1, upd: UPD_ADD};
            OP_SMSU: ctl = '{valid: 1'b1, is_signed: 1'b1, upd: UPD_SUB};
            default: ctl = '{valid: 1'b0, is_signed: 1'b0, upd: UPD_LOAD};
        endcase
    end

endmodule

// File: rtl/mac_product.sv
// Module: mac_product
// Single-cycle OPW x OPW multiplier. It serves both signed and unsigned
// operands by widening each operand by one bit (sign or zero) and using one
// signed multiplier. The product is then extended to ACCW bits.
// Assumes ACCW >= 2*OPW.
module mac_product #(
    parameter int OPW  = 16,
    parameter int ACCW = 48
) (
    input  logic [OPW-1:0]  a,
    input  logic [OPW-1:0]  b,
    input  logic            is_signed,
    output logic [ACCW-1:0] ext_prod
);

    localparam int PRODW = 2 * OPW;
    localparam int EXTW  = ACCW - PRODW;

    logic signed [OPW:0]     a_w;
    logic signed [OPW:0]     b_w;
    logic signed [PRODW+1:0] full;
    logic [PRODW-1:0]        prod;

    // Widen the operands according to the signedness of the code.
    always_comb begin
        a_w = {is_signed & a[OPW-1], a};
        b_w = {is_signed & b[OPW-1], b};
    end

    // One signed multiply covers both interpretations; the low PRODW bits are exact.
    always_comb begin
        full = a_w * b_w;
        prod = full[PRODW-1:0];
    end

    // Sign- or zero-extend the product to the accumulator width.
    generate
        if (EXTW > 0) begin : g_ext
            always_comb ext_prod = {{EXTW{is_signed & prod[PRODW-1]}}, prod};
        end else begin : g_noext
            always_comb ext_prod = prod[ACCW-1:0];
        end
    endgenerate

endmodule

// File: rtl/mac_acc_reg.sv
// Module: mac_acc_reg
// Holds the accumulator and the done flag. Applies clear (highest priority),
// then a valid start, otherwise holds. All arithmetic wraps at ACCW bits.
// Assumes the control word and product are stable in the cycle of the start strobe.
module mac_acc_reg
    import mac_pkg::*;
#(
    parameter int ACCW = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            acc_clr,
    input  mac_ctl_t        ctl,
    input  logic [ACCW-1:0] ext_prod,
    output logic [ACCW-1:0] acc,
    output logic            done
);

    localparam int PRODW_CHK = 32;

    logic [ACCW-1:0] acc_next;
    logic            fire;

    // Decide whether this cycle carries a valid, unblocked operation.
    always_comb fire = start & ctl.valid & ~acc_clr;

    // Combine the product with the current accumulator per the update kind.
    always_comb begin
        case (ctl.upd)
            UPD_LOAD:    acc_next = ext_prod;
            UPD_LOADNEG: acc_next = '0 - ext_prod;
            UPD_ADD:     acc_next = acc + ext_prod;
            UPD_SUB:     acc_next = acc - ext_prod;
            default:     acc_next = acc;
        endcase
    end

    // Register the accumulator and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            done <= 1'b0;
        end else if (acc_clr) begin
            acc  <= '0;
            done <= 1'b0;
        end else if (fire) begin
            acc  <= acc_next;
            done <= 1'b1;
        end else begin
            done <= 1'b0;
        end
    end

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc == '0) && !done);

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !acc_clr && !ctl.valid) |=> $stable(acc) && !done);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !acc_clr) |=> $stable(acc) && !done);

    p_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !acc_clr && ctl.valid) |=> done);

    p_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !acc_clr && ctl.valid && !ctl.is_signed && ctl.upd == UPD_LOAD)
        |=> (acc[ACCW-1:PRODW_CHK] == '0));

endmodule

// File: rtl/mac_unit.sv
// Module: mac_unit (top)
// Single-cycle multiply-accumulate unit. It offers seven signed/unsigned
// multiply variants on a wrapping accumulator, with a one-cycle done pulse.
// Assumes start is a one-cycle strobe and that code 7 is reserved.
module mac_unit
    import mac_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int ACCW = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OPW-1:0]  opa,
    input  logic [OPW-1:0]  opb,
    input  logic [2:0]      op_sel,
    input  logic            start,
    input  logic            acc_clr,
    output logic [ACCW-1:0] acc,
    output logic            done
);

    mac_ctl_t        ctl;
    logic [ACCW-1:0] ext_prod;

    mac_op_decode u_dec (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    mac_product #(.OPW(OPW), .ACCW(ACCW)) u_mul (
        .a         (opa),
        .b         (opb),
        .is_signed (ctl.is_signed),
        .ext_prod  (ext_prod)
    );

    mac_acc_reg #(.ACCW(ACCW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .acc_clr  (acc_clr),
        .ctl      (ctl),
        .ext_prod (ext_prod),
        .acc      (acc),
        .done     (done)
    );

endmodule

// File: tb/mac_unit_tb_top.sv
// Bench: behavioural reference model, compared against the DUT every cycle.
module mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] opa, opb;
    logic [2:0]  op_sel;
    logic        start, acc_clr;
    logic [47:0] acc;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [47:0] m_acc;
    logic        m_done;

    always #4 clk = ~clk;

    mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op_sel(op_sel),
        .start(start), .acc_clr(acc_clr), .acc(acc), .done(done)
    );

    function automatic string req_of(input logic [2:0] op, input bit st, input bit clr);
        if (clr) return "R11";
        if (!st) return "R12";
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Compare both outputs with the model, after the edge.
    task automatic check(input string req);
        n_chk++;
        if (acc !== m_acc || done !== m_done) begin
            n_fail++;
            $display("FAIL %s: acc=%h done=%b expected acc=%h done=%b",
                     req, acc, done, m_acc, m_done);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, and check at the next negedge.
    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                        input bit st, input bit clr, input string req);
        longint pa, pb;
        logic [47:0] p48;
        opa = a; opb = b; op_sel = op; start = st; acc_clr = clr;
        if (op >= 3'd3 && op <= 3'd6) begin
            pa = longint'($signed(a)); pb = longint'($signed(b));
        end else begin
            pa = longint'(a); pb = longint'(b);
        end
        p48 = 48'(pa * pb);
        m_done = 1'b0;
        if (clr) m_acc = '0;
        else if (st && op != 3'd7) begin
            m_done = 1'b1;
            case (op)
                3'd0, 3'd3: m_acc = p48;
                3'd4:       m_acc = 48'd0 - p48;
                3'd1, 3'd5: m_acc = m_acc + p48;
                default:    m_acc = m_acc - p48;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        rst_n = 1'b0; opa = '0; opb = '0; op_sel = '0; start = 0; acc_clr = 0;
        m_acc = '0; m_done = 0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        step(16'h0, 16'h0, 3'd0, 0, 0, "R1");
        step(16'hFFFF, 16'hFFFF, 3'd0, 1, 0, "R2");
        step(16'h1234, 16'h0010, 3'd1, 1, 0, "R3");
        step(16'h0003, 16'h0007, 3'd2, 1, 0, "R4");
        step(16'h0, 16'h0, 3'd0, 0, 0, "R12");
        step(16'hFFFF, 16'h0002, 3'd3, 1, 0, "R5");
        step(16'h8000, 16'h8000, 3'd3, 1, 0, "R5");
        step(16'h0005, 16'h0003, 3'd4, 1, 0, "R6");
        step(16'hFFFB, 16'h0003, 3'd4, 1, 0, "R6");
        step(16'hFFF0, 16'h0100, 3'd5, 1, 0, "R7");
        step(16'hFFF0, 16'hFFF0, 3'd6, 1, 0, "R8");
        step(16'h7FFF, 16'h8000, 3'd6, 1, 0, "R8");
        step(16'h1111, 16'h2222, 3'd7, 1, 0, "R9");
        step(16'h0, 16'h0, 3'd0, 0, 1, "R11");
        step(16'h0001, 16'h0001, 3'd2, 1, 0, "R10");
        step(16'h0001, 16'h0001, 3'd1, 1, 0, "R10");
        step(16'h0009, 16'h0009, 3'd0, 1, 0, "R2");
        step(16'h00FF, 16'h00FF, 3'd1, 1, 1, "R11");
        step(16'h0, 16'h0, 3'd0, 0, 0, "R12");
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            bit st, clr;
            op  = 3'($urandom_range(0, 7));
            st  = ($urandom_range(0, 3) != 0);
            clr = ($urandom_range(0, 15) == 0);
            step(16'($urandom), 16'($urandom), op, st, clr, req_of(op, st, clr));
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: acc=%h done=%b expected completion", acc, done);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule